// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Marker

This block takes one fast reference clock and produces three banks of divided clocks (A, B, C) plus a feedback clock. Each of the four has its own 2-bit divide select. All dividers start counting together when reset is released, so every bank rises on the same reference edge at the start. Two lanes of bank C can be inverted one at a time. The divided clocks and the marker are flip-flop outputs, so they switch only on reference edges.

A marker output, `coin_sync`, tracks banks A and C only. It drops one period of the faster of the two banks before their next shared rising edge, and it returns high on that shared edge. The marker is driven from a counter that wraps at the least common multiple of the two ratios. This keeps it correct when one ratio is not a whole multiple of the other, for example 6 and 8.

Top module: `multibank_clkdiv`

## Requirements
- R1: While `rst_n` is low and at least one reference edge has occurred, every bank lane and `q_fb` read 0, `coin_sync` reads 1, and the two invertible C lanes read their `inv_c` bit.
- R2: Select code c gives divide ratio R = 2*(c+1): code 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8. After reference edge k following reset release, bank A is high when (k-1) mod R < R/2.
- R3: Bank B and `q_fb` follow the rule of R2 with their own selects, independent of banks A and C.
- R4: `qc[1:0]` both carry the bank C clock, which follows R2 with `sel_c`. All lanes of banks A and B are equal.
- R5: `qc[2]` equals the bank C clock XOR `inv_c[0]`, and `qc[3]` equals the bank C clock XOR `inv_c[1]`. A change to `inv_c` shows up at once.
- R6: The selects are captured only while `rst_n` is low. Changing them after release has no effect on any output.
- R7: `coin_sync` is high on every reference cycle in which banks A and C rise together, and it rises only on such a cycle.
- R8: Let L be the least common multiple of the A and C ratios and F the smaller ratio. With g = (k-1) mod L, `coin_sync` is low after edge k exactly when g is nonzero and g >= L-F. The low stretch therefore lasts F cycles, or F-1 cycles when L equals F.
- R9: After reset release, `coin_sync` stays high until the first low window of R8.
- R10: R7 and R8 hold when the A and C ratios are not integer multiples of each other (4 with 6, and 6 with 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; selects are captured while it is low |
| sel_a | input | 2 | Bank A divide select |
| sel_b | input | 2 | Bank B divide select |
| sel_c | input | 2 | Bank C divide select |
| sel_fb | input | 2 | Feedback divide select |
| inv_c | input | 2 | Invert controls for `qc[2]` and `qc[3]` |
| qa | output | 4 | Bank A clock lanes |
| qb | output | 4 | Bank B clock lanes |
| qc | output | 4 | Bank C clock lanes; the upper two can be inverted |
| q_fb | output | 1 | Feedback clock |
| coin_sync | output | 1 | Marker that is low ahead of each shared A/C rising edge |

## Verification
The assertions measure periods and the marker's low-run length against the captured select codes. They therefore assume that reset lasts at least one reference edge, so that a valid code is captured before counting starts. The bench holds reset for two edges on every scenario. It changes the select inputs only after release, which is exactly where R6 says they must be ignored. The bench sweeps all sixteen A/C ratio pairs, including pairs that are not multiples of each other and pairs that are equal. Each pair runs for more than two full coincidence periods, so the assertions see several complete low windows and period wraps.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  // Divide ratio for a select code: 2, 4, 6, 8 ...
  function automatic int unsigned mbd_ratio(int unsigned code);
    return 2 * (code + 1);
  endfunction

  // Smallest common multiple of a and b. The scan runs downward so that the
  // smallest hit is the one kept.
  function automatic int unsigned mbd_lcm(int unsigned a, int unsigned b);
    int unsigned r;
    r = a * b;
    for (int unsigned k = 64; k > 0; k--) begin
      if (((a * k) % b) == 0) r = a * k;
    end
    return r;
  endfunction

endpackage

// File: rtl/mbd_bank_div.sv
module mbd_bank_div #(
  parameter int SEL_W = 2,
  localparam int CW = SEL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code,
  output logic             clk_o,
  output logic             rise_next
);
  import mbd_pkg::*;

  logic [CW-1:0] ratio_w;
  logic [CW-1:0] half_w;
  logic [CW-1:0] cnt;

  always_comb begin
    ratio_w = CW'(mbd_ratio(32'(code)));
    half_w  = ratio_w >> 1;
  end

  // cnt == 0 means the output rises on the coming edge
  assign rise_next = rst_n && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else begin
      cnt   <= (cnt == ratio_w - CW'(1)) ? '0 : cnt + CW'(1);
      clk_o <= (cnt < half_w);
    end
  end

endmodule

// File: rtl/mbd_sync_gen.sv
module mbd_sync_gen #(
  parameter int SEL_W = 2,
  localparam int RW = SEL_W + 2,
  localparam int LW = 2 * RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code_a,
  input  logic [SEL_W-1:0] code_c,
  output logic             sync_o,
  output logic             coin_evt
);
  import mbd_pkg::*;

  logic [RW-1:0] ra, rc, fast;
  logic [LW-1:0] lcm, wstart, g;
  logic          in_window;

  always_comb begin
    ra        = RW'(mbd_ratio(32'(code_a)));
    rc        = RW'(mbd_ratio(32'(code_c)));
    fast      = (ra < rc) ? ra : rc;
    lcm       = LW'(mbd_lcm(32'(ra), 32'(rc)));
    wstart    = lcm - LW'(fast);
    in_window = (g >= wstart) && (g != '0);
  end

  // g == 0: banks A and C both rise on the coming edge
  assign coin_evt = rst_n && (g == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g      <= '0;
      sync_o <= 1'b1;
    end else begin
      g      <= (g == lcm - LW'(1)) ? '0 : g + LW'(1);
      sync_o <= !in_window;
    end
  end

endmodule

// File: rtl/multibank_clkdiv.sv
module multibank_clkdiv #(
  parameter int SEL_W = 2,
  parameter int N_A   = 4,
  parameter int N_B   = 4,
  parameter int N_C   = 4,
  parameter int N_INV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  input  logic [SEL_W-1:0] sel_c,
  input  logic [SEL_W-1:0] sel_fb,
  input  logic [N_INV-1:0] inv_c,
  output logic [N_A-1:0]   qa,
  output logic [N_B-1:0]   qb,
  output logic [N_C-1:0]   qc,
  output logic             q_fb,
  output logic             coin_sync
);
  localparam int N_PLAIN_C = N_C - N_INV;

  // Selects captured during reset only
  logic [SEL_W-1:0] lat_a, lat_b, lat_c, lat_fb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a  <= sel_a;
      lat_b  <= sel_b;
      lat_c  <= sel_c;
      lat_fb <= sel_fb;
    end
  end

  logic clk_a, clk_b, clk_c;
  logic rise_a, rise_b, rise_c, rise_fb;
  logic coin_evt;

  mbd_bank_div #(.SEL_W(SEL_W)) u_div_a (
    .clk(clk), .rst_n(rst_n), .code(lat_a), .clk_o(clk_a), .rise_next(rise_a));
  mbd_bank_div #(.SEL_W(SEL_W)) u_div_b (
    .clk(clk), .rst_n(rst_n), .code(lat_b), .clk_o(clk_b), .rise_next(rise_b));
  mbd_bank_div #(.SEL_W(SEL_W)) u_div_c (
    .clk(clk), .rst_n(rst_n), .code(lat_c), .clk_o(clk_c), .rise_next(rise_c));
  mbd_bank_div #(.SEL_W(SEL_W)) u_div_fb (
    .clk(clk), .rst_n(rst_n), .code(lat_fb), .clk_o(q_fb), .rise_next(rise_fb));

  mbd_sync_gen #(.SEL_W(SEL_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .code_a(lat_a), .code_c(lat_c),
    .sync_o(coin_sync), .coin_evt(coin_evt));

  assign qa = {N_A{clk_a}};
  assign qb = {N_B{clk_b}};

  generate
    for (genvar i = 0; i < N_PLAIN_C; i++) begin : g_cplain
      assign qc[i] = clk_c;
    end
    for (genvar j = 0; j < N_INV; j++) begin : g_cinv
      assign qc[N_PLAIN_C + j] = clk_c ^ inv_c[j];
    end
  endgenerate

endmodule

// File: rtl/mbd_chk.sv
module mbd_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             qa0,
  input logic             qb0,
  input logic             qc0,
  input logic             qfb,
  input logic             sync_o,
  input logic             coin_evt,
  input logic [SEL_W-1:0] code_a,
  input logic [SEL_W-1:0] code_b,
  input logic [SEL_W-1:0] code_c,
  input logic [SEL_W-1:0] code_fb
);
  import mbd_pkg::*;

  logic [3:0]       clks;
  logic [SEL_W-1:0] codes [4];
  assign clks = {qfb, qc0, qb0, qa0};
  assign codes[0] = code_a;
  assign codes[1] = code_b;
  assign codes[2] = code_c;
  assign codes[3] = code_fb;

  int unsigned ra, rc, fa, la, exp_low;
  always_comb begin
    ra      = mbd_ratio(32'(code_a));
    rc      = mbd_ratio(32'(code_c));
    fa      = (ra < rc) ? ra : rc;
    la      = mbd_lcm(ra, rc);
    exp_low = (la == fa) ? fa - 1 : fa;
  end

  logic [7:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)      low_run <= '0;
    else if (!sync_o) low_run <= low_run + 8'd1;
    else             low_run <= '0;
  end

  // R7
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> ($rose(qa0) && $rose(qc0)));

  // R7
  coin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(qa0) && $rose(qc0)) |-> sync_o);

  // R10
  coin_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coin_evt |=> ($rose(qa0) && $rose(qc0)));

  // R8
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (32'(low_run) == exp_low));

  generate
    for (genvar b = 0; b < 4; b++) begin : g_per
      logic       prev_q, seen;
      logic [7:0] since;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          seen   <= 1'b0;
          since  <= '0;
        end else begin
          prev_q <= clks[b];
          if (clks[b] && !prev_q) begin
            seen  <= 1'b1;
            since <= 8'd1;
          end else begin
            since <= since + 8'd1;
          end
        end
      end
      // R3
      period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clks[b]) && seen) |-> (32'(since) == mbd_ratio(32'(codes[b]))));
    end
  endgenerate

endmodule

bind multibank_clkdiv mbd_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .qa0(qa[0]), .qb0(qb[0]), .qc0(qc[0]), .qfb(q_fb),
  .sync_o(coin_sync), .coin_evt(coin_evt), .code_a(lat_a), .code_b(lat_b),
  .code_c(lat_c), .code_fb(lat_fb));

// File: tb/multibank_clkdiv_tb.sv
`timescale 1ns/1ps
module multibank_clkdiv_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0, sel_fb = '0, inv_c = '0;
  logic [3:0] qa, qb, qc;
  logic       q_fb, coin_sync;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  multibank_clkdiv u_dut (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .sel_fb(sel_fb), .inv_c(inv_c), .qa(qa), .qb(qb), .qc(qc), .q_fb(q_fb),
    .coin_sync(coin_sync));

  task automatic chk(string tag, int k, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  function automatic logic mclk(int code, int k);
    int r = 2 * code + 2;
    return ((k - 1) % r) < (r / 2);
  endfunction

  function automatic int common(int a, int c);
    int m = (a > c) ? a : c;
    while ((m % a) != 0 || (m % c) != 0) m++;
    return m;
  endfunction

  // Marker model: low once the next shared rise is within the faster period
  function automatic logic msync(int ca, int cc, int k);
    int a = 2 * ca + 2, c = 2 * cc + 2;
    int l = common(a, c), f = (a < c) ? a : c;
    int pos = (k - 1) % l;
    int left = l - pos;
    return !(pos != 0 && left <= f);
  endfunction

  task automatic run_case(int ca, int cb, int cc, int cf, logic [1:0] inv, bit swap);
    int a = 2 * ca + 2, c = 2 * cc + 2;
    int l = common(a, c), f = (a < c) ? a : c;
    int n = 2 * l + 3;
    @(negedge clk);
    rst_n = 1'b0;
    sel_a = 2'(ca); sel_b = 2'(cb); sel_c = 2'(cc); sel_fb = 2'(cf); inv_c = inv;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", 0, qa | qb | {3'b0, q_fb}, 4'b0);
    chk("R1", 0, {3'b0, coin_sync}, 4'b1);
    chk("R1", 0, qc, {inv, 2'b00});
    rst_n = 1'b1;
    for (int k = 1; k <= n; k++) begin
      logic e_a, e_b, e_c, e_f, e_s;
      string t_clk, t_sync;
      @(negedge clk);
      if (swap && k == 3) begin
        sel_a = ~sel_a; sel_b = ~sel_b; sel_c = ~sel_c; sel_fb = ~sel_fb;
      end
      e_a = mclk(ca, k); e_b = mclk(cb, k); e_c = mclk(cc, k); e_f = mclk(cf, k);
      e_s = msync(ca, cc, k);
      if (swap && k > 3) begin
        t_clk = "R6"; t_sync = "R6";
      end else begin
        t_clk = "R2";
        if (k - 1 < l - f) t_sync = "R9";
        else if (l != a && l != c) t_sync = "R10";
        else if (((k - 1) % l) == 0) t_sync = "R7";
        else t_sync = "R8";
      end
      chk(t_clk, k, qa, {4{e_a}});
      chk((t_clk == "R6") ? "R6" : "R3", k, {qb[3:1], q_fb}, {{3{e_b}}, e_f});
      chk((t_clk == "R6") ? "R6" : "R4", k, {2'b00, qc[1:0]}, {2'b00, e_c, e_c});
      chk("R5", k, {2'b00, qc[3:2]}, {2'b00, e_c ^ inv[1], e_c ^ inv[0]});
      chk(t_sync, k, {3'b0, coin_sync}, {3'b0, e_s});
    end
  endtask

  task automatic t_sweep_ac();
    for (int ia = 0; ia < 4; ia++)
      for (int ic = 0; ic < 4; ic++)
        run_case(ia, (ia + ic) % 4, ic, 3 - ia, 2'(ia + ic), 1'b0);
  endtask

  task automatic t_select_ignored();
    run_case(2, 1, 3, 0, 2'b01, 1'b1);
    run_case(1, 3, 2, 2, 2'b10, 1'b1);
  endtask

  // R5: invert controls change while running
  task automatic t_invert_live();
    run_case(1, 1, 1, 1, 2'b00, 1'b0);
    @(negedge clk);
    inv_c = 2'b10;
    #0.1;
    chk("R5", 0, {2'b00, qc[3:2]}, {2'b00, ~qc[0], qc[0]});
    inv_c = 2'b01;
    #0.1;
    chk("R5", 0, {2'b00, qc[3:2]}, {2'b00, qc[0], ~qc[0]});
  endtask

  initial begin
    t_sweep_ac();
    t_select_ignored();
    t_invert_live();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule